// File: doc/BRIEF.md
# Sequential Arithmetic Right Shifter

This unit shifts a signed byte or 16-bit word to the right, one bit position per clock cycle, and copies the operand's sign bit into each vacated high-order position. A start pulse loads the operand, the width select and an 8-bit count. After one setup cycle the unit performs as many single-bit steps as the low five bits of the count ask for. It then raises `done` for one cycle. In that cycle it presents the result, the new carry, overflow, sign, zero and parity values, and one write-enable per flag, so that the surrounding flag register is updated only where the operation defines a value.

The carry flag takes the last bit that left the low end. The overflow flag is cleared when exactly one step was made. When more steps were made, overflow is still written as 0, but `of_valid` stays low to mark the value as having no defined meaning. A count that reduces to zero leaves every flag untouched and returns the operand unchanged. The auxiliary-carry flag has no enable, so the flag register keeps its old value.

Top module: `sar_serial_unit`

## Requirements
- R1: Each step moves the selected field right by one bit and fills the top bit of the field with the operand's original sign bit (bit 15 when `wide`=1, bit 7 when `wide`=0). In byte mode `result[15:8]` is 0.
- R2: Only `count[4:0]` is used, so the effective step count is `count` mod 32.
- R3: `flag_c` equals the last bit shifted out of bit 0. When the effective count is at least the field width, the result is all copies of the sign bit and `flag_c` equals the sign bit.
- R4: `flag_o` is always 0. With an effective count of 1, `we_o` and `of_valid` are high in the done cycle. With an effective count above 1, `we_o` is high and `of_valid` is low.
- R5: `flag_s` is the top bit of the selected field of `result`. `flag_z` is 1 when the selected field is all zeros. `flag_p` is 1 when `result[7:0]` holds an even number of ones.
- R6: With an effective count of 0, `result` equals the operand (zero-extended in byte mode), and `we_c`, `we_o`, `we_s`, `we_z`, `we_p` and `of_valid` all stay low.
- R7: `done` is a one-cycle pulse that comes 1+N clock edges after the accepting edge, where N is the effective count. `busy` is high from the accepting edge through the done cycle.
- R8: `start` is accepted only while `busy` is low. Operand, width and count are sampled only on the accepting edge, so input changes and start pulses during `busy` have no effect.
- R9: The flag write-enables are high only in the done cycle, and only for a nonzero effective count.
- R10: After `done`, `result` and the flag values hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| operand | input | 16 | Value to shift (low byte in byte mode) |
| wide | input | 1 | 1 = 16-bit field, 0 = 8-bit field |
| count | input | 8 | Shift count, reduced mod 32 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted value |
| flag_c | output | 1 | Carry value |
| flag_o | output | 1 | Overflow value |
| flag_s | output | 1 | Sign value |
| flag_z | output | 1 | Zero value |
| flag_p | output | 1 | Parity value |
| we_c | output | 1 | Carry write-enable |
| we_o | output | 1 | Overflow write-enable |
| we_s | output | 1 | Sign write-enable |
| we_z | output | 1 | Zero write-enable |
| we_p | output | 1 | Parity write-enable |
| of_valid | output | 1 | Overflow value is architecturally defined |

## Verification
The checker takes for granted that `start` matters only while `busy` is low. It therefore reconstructs the operand, width and effective count from the accepting edge, and it never tries to relate outputs to inputs presented during an operation. It also assumes that the flag outputs mean something only while `done` is high, except for the hold rule. The stimulus drives every input on the falling edge. It lowers `start` before `done` in the busy-overlap scenario, so an overlapping request cannot be taken as a new operation at the return to idle. It then waits for `done` before issuing the next operation.

// File: rtl/sar_pkg.sv
// Package: shared state encoding and constants for the serial
// arithmetic right shifter. Assumes no other package defines these names.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_FIN   = 2'd3
    } sar_state_e;

    // number of count bits that survive the modulo reduction
    localparam int unsigned SAR_KEEP_W = 5;
endpackage

// File: rtl/sar_sequencer.sv
// Sequencer: accepts a start request while idle, holds the masked step
// count, spends one setup cycle, issues one step per cycle and ends with
// a one-cycle completion state. Assumes count bits above KEEP_W are
// dropped by the caller.
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int unsigned KEEP_W = SAR_KEEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KEEP_W-1:0] cnt_in,
    output logic              load,
    output logic              step,
    output logic              busy,
    output logic              done,
    output logic              cnt_nz,
    output logic              cnt_one
);
    localparam logic [KEEP_W-1:0] ONE = KEEP_W'(1);
    localparam logic [KEEP_W-1:0] ZERO = '0;

    sar_state_e        state_q;
    logic [KEEP_W-1:0] rem_q;

    // accept a request only in idle
    assign load = start && (state_q == ST_IDLE);
    // shift strobe for the datapath
    assign step = (state_q == ST_SHIFT);
    // handshake outputs decoded from state
    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FIN);

    // state, remaining count and count class registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= ZERO;
            cnt_nz  <= 1'b0;
            cnt_one <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        rem_q   <= cnt_in;
                        cnt_nz  <= (cnt_in != ZERO);
                        cnt_one <= (cnt_in == ONE);
                        state_q <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    state_q <= (rem_q == ZERO) ? ST_FIN : ST_SHIFT;
                end
                ST_SHIFT: begin
                    rem_q <= rem_q - ONE;
                    if (rem_q == ONE) begin
                        state_q <= ST_FIN;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sar_step_unit.sv
// Step datapath: captures the operand (zero-extended in narrow mode) and
// its sign bit, then on each step moves the selected field right by one,
// fills the top with the sign and records the bit that left bit 0.
// Assumes load and step are never high together.
module sar_step_unit #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] operand,
    input  logic              wide,
    output logic [DATA_W-1:0] data_q,
    output logic              carry_q,
    output logic              wide_q
);
    localparam int unsigned HI_W = DATA_W - NARROW_W;

    logic              sign_q;
    logic [DATA_W-1:0] next_wide;
    logic [DATA_W-1:0] next_narrow;

    // per-bit next value for each width; the top of each field takes the sign
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        if (gi == DATA_W - 1) begin : g_wtop
            assign next_wide[gi] = sign_q;
        end else begin : g_wmid
            assign next_wide[gi] = data_q[gi+1];
        end
        if (gi == NARROW_W - 1) begin : g_ntop
            assign next_narrow[gi] = sign_q;
        end else if (gi < NARROW_W - 1) begin : g_nmid
            assign next_narrow[gi] = data_q[gi+1];
        end else begin : g_nhi
            assign next_narrow[gi] = 1'b0;
        end
    end

    // operand capture and one-bit step register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            carry_q <= 1'b0;
            wide_q  <= 1'b0;
            sign_q  <= 1'b0;
        end else if (load) begin
            wide_q  <= wide;
            carry_q <= 1'b0;
            sign_q  <= wide ? operand[DATA_W-1] : operand[NARROW_W-1];
            data_q  <= wide ? operand : {{HI_W{1'b0}}, operand[NARROW_W-1:0]};
        end else if (step) begin
            carry_q <= data_q[0];
            data_q  <= wide_q ? next_wide : next_narrow;
        end
    end
endmodule

// File: rtl/sar_flag_gen.sv
// Flag generator: derives sign, zero and parity from the held result,
// passes the captured carry, and gates every write-enable with the
// completion cycle and a nonzero effective count. Assumes data holds the
// final result whenever done is high.
module sar_flag_gen #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned PAR_W    = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              wide,
    input  logic              carry,
    input  logic              cnt_nz,
    input  logic              cnt_one,
    input  logic              done,
    output logic              flag_c,
    output logic              flag_o,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_p,
    output logic              we_c,
    output logic              we_o,
    output logic              we_s,
    output logic              we_z,
    output logic              we_p,
    output logic              of_valid
);
    logic write_all;

    // flag values from the result of the selected width
    always_comb begin
        flag_c = carry;
        flag_o = 1'b0;
        flag_s = wide ? data[DATA_W-1] : data[NARROW_W-1];
        flag_z = wide ? (data == '0) : (data[NARROW_W-1:0] == '0);
        flag_p = ~^data[PAR_W-1:0];
    end

    // write-enables only in the completion cycle of a nonzero count
    assign write_all = done && cnt_nz;
    assign we_c      = write_all;
    assign we_o      = write_all;
    assign we_s      = write_all;
    assign we_z      = write_all;
    assign we_p      = write_all;
    assign of_valid  = done && cnt_one;
endmodule

// File: rtl/sar_serial_unit.sv
// Top: serial arithmetic right shifter with flag outputs. Connects the
// sequencer, the step datapath and the flag generator. Assumes the
// caller writes flags only where the matching enable is high.
module sar_serial_unit
    import sar_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned KEEP_W   = SAR_KEEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic              wide,
    input  logic [CNT_W-1:0]  count,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              flag_c,
    output logic              flag_o,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_p,
    output logic              we_c,
    output logic              we_o,
    output logic              we_s,
    output logic              we_z,
    output logic              we_p,
    output logic              of_valid
);
    logic              load;
    logic              step;
    logic              cnt_nz;
    logic              cnt_one;
    logic [DATA_W-1:0] data_q;
    logic              carry_q;
    logic              wide_q;
    logic [KEEP_W-1:0] cnt_masked;

    // modulo reduction of the step count
    assign cnt_masked = count[KEEP_W-1:0];

    sar_sequencer #(
        .KEEP_W (KEEP_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cnt_in  (cnt_masked),
        .load    (load),
        .step    (step),
        .busy    (busy),
        .done    (done),
        .cnt_nz  (cnt_nz),
        .cnt_one (cnt_one)
    );

    sar_step_unit #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .operand (operand),
        .wide    (wide),
        .data_q  (data_q),
        .carry_q (carry_q),
        .wide_q  (wide_q)
    );

    sar_flag_gen #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .PAR_W    (NARROW_W)
    ) u_flags (
        .data     (data_q),
        .wide     (wide_q),
        .carry    (carry_q),
        .cnt_nz   (cnt_nz),
        .cnt_one  (cnt_one),
        .done     (done),
        .flag_c   (flag_c),
        .flag_o   (flag_o),
        .flag_s   (flag_s),
        .flag_z   (flag_z),
        .flag_p   (flag_p),
        .we_c     (we_c),
        .we_o     (we_o),
        .we_s     (we_s),
        .we_z     (we_z),
        .we_p     (we_p),
        .of_valid (of_valid)
    );

    assign result = data_q;
endmodule

// File: rtl/sar_serial_unit_chk.sv
// Checker: protocol and flag properties of the serial shifter, observed
// at its ports. It keeps its own copy of what was accepted at each start.
module sar_serial_unit_chk #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned KEEP_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] operand,
    input logic              wide,
    input logic [CNT_W-1:0]  count,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              flag_o,
    input logic              we_c,
    input logic              we_o,
    input logic              we_s,
    input logic              we_z,
    input logic              we_p,
    input logic              of_valid
);
    localparam int unsigned HI_W = DATA_W - NARROW_W;

    logic              byte_q;
    logic              zero_q;
    logic              one_q;
    logic [DATA_W-1:0] op_q;

    // record what the unit accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= 1'b0;
            zero_q <= 1'b0;
            one_q  <= 1'b0;
            op_q   <= '0;
        end else if (start && !busy) begin
            byte_q <= !wide;
            zero_q <= (count[KEEP_W-1:0] == '0);
            one_q  <= (count[KEEP_W-1:0] == KEEP_W'(1));
            op_q   <= wide ? operand : {{HI_W{1'b0}}, operand[NARROW_W-1:0]};
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_o);
    // R4
    of_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        of_valid |-> (one_q && we_o));
    // R9
    we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_c || we_o || we_s || we_z || we_p) |-> (done && !zero_q));
    // R1
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && byte_q) |-> (result[DATA_W-1:NARROW_W] == '0));
    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_q) |-> (result == op_q && !of_valid));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
endmodule

bind sar_serial_unit sar_serial_unit_chk #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .CNT_W    (CNT_W),
    .KEEP_W   (KEEP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .operand  (operand),
    .wide     (wide),
    .count    (count),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .flag_o   (flag_o),
    .we_c     (we_c),
    .we_o     (we_o),
    .we_s     (we_s),
    .we_z     (we_z),
    .we_p     (we_p),
    .of_valid (of_valid)
);

// File: tb/sim_sar_serial_unit.sv
module sim_sar_serial_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] operand = '0;
    logic        wide = 1'b0;
    logic [7:0]  count = '0;
    logic        busy, done;
    logic [15:0] result;
    logic        flag_c, flag_o, flag_s, flag_z, flag_p;
    logic        we_c, we_o, we_s, we_z, we_p, of_valid;

    int n_checks = 0;
    int n_fail = 0;
    int wd = 0;

    always #10 clk = ~clk;   // 50 MHz

    sar_serial_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .wide(wide), .count(count), .busy(busy), .done(done),
        .result(result), .flag_c(flag_c), .flag_o(flag_o),
        .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p),
        .we_c(we_c), .we_o(we_o), .we_s(we_s), .we_z(we_z),
        .we_p(we_p), .of_valid(of_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference: arithmetic right shift of the selected field by count mod 32
    task automatic model(input logic [15:0] op, input logic w,
                         input logic [7:0] c, output logic [15:0] r,
                         output logic cy);
        int n;
        logic s;
        n  = int'(c[4:0]);
        r  = w ? op : {8'h00, op[7:0]};
        s  = w ? op[15] : op[7];
        cy = 1'b0;
        for (int i = 0; i < n; i++) begin
            cy = r[0];
            r  = w ? {s, r[15:1]} : {8'h00, s, r[7:1]};
        end
    endtask

    task automatic issue(input logic [15:0] op, input logic w, input logic [7:0] c);
        @(negedge clk);
        operand = op; wide = w; count = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // full operation with latency, result and flag checks
    task automatic run_op(input logic [15:0] op, input logic w, input logic [7:0] c);
        logic [15:0] er;
        logic ecy, ez;
        int n, cyc;
        model(op, w, c, er, ecy);
        n = int'(c[4:0]);
        issue(op, w, c);
        check(busy === 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 1 + n, "R7 latency", cyc, 1 + n);
        check(result === er, (n == 0) ? "R6 result" : "R1 R2 R3 result", 32'(result), 32'(er));
        if (n == 0) begin
            check({we_c, we_o, we_s, we_z, we_p, of_valid} === 6'b0,
                  "R6 enables low", 32'({we_c, we_o, we_s, we_z, we_p, of_valid}), 32'd0);
        end else begin
            ez = w ? (er == 16'h0) : (er[7:0] == 8'h0);
            check({we_c, we_o, we_s, we_z, we_p} === 5'h1f, "R9 enables high",
                  32'({we_c, we_o, we_s, we_z, we_p}), 32'h1f);
            check(flag_c === ecy, "R3 carry", 32'(flag_c), 32'(ecy));
            check(flag_o === 1'b0, "R4 overflow value", 32'(flag_o), 32'd0);
            check(of_valid === (n == 1), "R4 of_valid", 32'(of_valid), 32'(n == 1));
            check(flag_s === (w ? er[15] : er[7]), "R5 sign", 32'(flag_s), 32'(w ? er[15] : er[7]));
            check(flag_z === ez, "R5 zero", 32'(flag_z), 32'(ez));
            check(flag_p === ~^er[7:0], "R5 parity", 32'(flag_p), 32'(~^er[7:0]));
        end
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R7 single done pulse",
              32'({done, busy}), 32'd0);
    endtask

    task automatic t_reset;
        check({busy, done} === 2'b00, "R7 reset handshake", 32'({busy, done}), 32'd0);
        check(result === 16'h0, "R10 reset result", 32'(result), 32'd0);
        check({we_c, we_o, we_s, we_z, we_p, of_valid} === 6'b0, "R9 reset enables",
              32'({we_c, we_o, we_s, we_z, we_p, of_valid}), 32'd0);
    endtask

    task automatic t_word;
        run_op(16'h8001, 1'b1, 8'd1);   // 0xC000, carry 1, of_valid
        run_op(16'h7FF0, 1'b1, 8'd4);   // 0x07FF
        run_op(16'hF00F, 1'b1, 8'd7);
    endtask

    task automatic t_byte;
        run_op(16'h3C85, 1'b0, 8'd3);   // 0xF0, carry 1
        run_op(16'hFF42, 1'b0, 8'd2);   // upper operand byte ignored
    endtask

    task automatic t_mask;
        run_op(16'h8421, 1'b1, 8'h23);  // R2: 35 -> 3
        run_op(16'h00A5, 1'b0, 8'hE1);  // R2: 225 -> 1
        run_op(16'hABCD, 1'b1, 8'h20);  // R2 R6: 32 -> 0
    endtask

    task automatic t_wide_counts;
        run_op(16'h0080, 1'b0, 8'd9);   // R3: byte all ones, carry 1
        run_op(16'h1234, 1'b1, 8'd31);  // R3: zero result, carry 0
        run_op(16'h8000, 1'b1, 8'd16);  // R3: all ones
        run_op(16'h0040, 1'b0, 8'd8);   // R3: zero, carry 0
    endtask

    task automatic t_zero;
        run_op(16'hABCD, 1'b1, 8'd0);   // R6
        run_op(16'h5A99, 1'b0, 8'd0);   // R6 byte zero-extended
    endtask

    // R8: start and input changes during busy are ignored
    task automatic t_busy_ignore;
        int cyc;
        issue(16'h8000, 1'b1, 8'd5);
        start = 1'b1; operand = 16'h1111; wide = 1'b0; count = 8'd0;
        cyc = 0;
        while (done !== 1'b1 && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (cyc == 3) start = 1'b0;
        end
        check(cyc == 6, "R8 latency unaffected", cyc, 6);
        check(result === 16'hFC00, "R8 result unaffected", 32'(result), 32'hFC00);
        @(negedge clk);
        check(busy === 1'b0, "R8 no second operation", 32'(busy), 32'd0);
    endtask

    // R10: outputs hold after completion while idle
    task automatic t_hold;
        logic [15:0] keep;
        logic [2:0] fk;
        run_op(16'h9357, 1'b1, 8'd3);
        keep = result;
        fk = {flag_c, flag_s, flag_p};
        for (int i = 0; i < 4; i++) begin
            operand = 16'(i * 16'h1357); count = 8'(i);
            @(negedge clk);
        end
        check(result === keep, "R10 result hold", 32'(result), 32'(keep));
        check({flag_c, flag_s, flag_p} === fk, "R10 flag hold",
              32'({flag_c, flag_s, flag_p}), 32'(fk));
        check({we_c, we_o, we_s, we_z, we_p} === 5'b0, "R9 enables idle",
              32'({we_c, we_o, we_s, we_z, we_p}), 32'd0);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_byte();
        t_mask();
        t_wide_counts();
        t_zero();
        t_busy_ignore();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule